// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences an 8-bit successive-approximation analog-to-digital conversion. An external comparator reports whether the DAC level is above the analog input. The controller drives the DAC with a trial code and resolves one bit per falling clock edge, from the most significant bit to the least. It raises an active-low busy flag back to high when the result is ready. A read port shows the approximation register on a data bus while an active-low read enable is held low. The bus's high-impedance state is modelled by a separate output-enable signal.

A conversion is started by an active-low strobe `conv_n`, which may change at any time relative to the clock. While the strobe is low, the register is held cleared to the midscale trial code and busy is low. This clear is asynchronous, so a pulse shorter than a clock period is still seen. The rising edge of the strobe is retimed through a chain of `SYNC_STAGES` rising-edge flops, and the first decision is taken on the falling edge that follows. A new strobe abandons any conversion in progress.

The sequencer states are ST_DONE, ST_HOLD and ST_RUN. Reset enters ST_DONE. A low strobe enters ST_HOLD from any state. ST_HOLD moves to ST_RUN on the falling edge where the retimed release is high, which is also the MSB decision. ST_RUN stays in ST_RUN while lower bits remain, and moves to ST_DONE on the LSB decision. ST_DONE holds until the next strobe.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While `conv_n` is low, `busy_n` is 0 and `trial` is 8'h80, held across any number of clock edges.
- R2: A low pulse on `conv_n` during a conversion abandons it. A complete new conversion follows, and its result reflects only the input present after the pulse.
- R3: After `conv_n` returns high, the MSB decision is taken on the first falling clock edge that follows the second rising edge (`SYNC_STAGES` = 2). Before that edge, `trial` stays 8'h80.
- R4: At each decision, the bit under test becomes 0 if `cmp_hi` is 1 (DAC above input) and stays 1 otherwise. On the same edge, the next lower bit is set to 1.
- R5: The eight decisions run from bit 7 down to bit 0. For an input of v LSB, the final code equals floor(v), clamped to 0..255.
- R6: `busy_n` goes to 1 on the falling edge of the LSB decision. That is the eighth decision edge, counting the MSB edge as the first.
- R7: When `rd_n` is 0, `dout_oe` is 1 and `dout` equals `trial`. When `rd_n` is 1, `dout_oe` is 0 and `dout` is 8'h00.
- R8: Reading changes nothing: repeated reads return the same code, and `trial` is unchanged by `rd_n`.
- R9: After completion, `trial` holds its result and `busy_n` stays 1 until the next strobe. `cmp_hi` has no effect in this state.
- R10: A strobe pulse shorter than half a clock period, lying between clock edges, clears the register to 8'h80 and drops `busy_n` immediately. It then starts a full conversion.
- R11: During and after reset, `busy_n` is 1, `trial` is 8'h00 and `dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; decisions on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_n | input | 1 | Asynchronous active-low convert strobe |
| cmp_hi | input | 1 | Comparator: 1 when the DAC level is above the analog input |
| rd_n | input | 1 | Active-low read enable for the data bus |
| trial | output | 8 | Approximation register, drives the DAC |
| busy_n | output | 1 | Low while a conversion is pending or running |
| dout | output | 8 | Data bus value, valid while `dout_oe` is 1 |
| dout_oe | output | 1 | Bus driver enable; 0 models high impedance |

## Verification
The read port and the final bit decision can fall in the same cycle. The bench holds `rd_n` low through an entire conversion, so the bus follows every trial code and is sampled just after the LSB edge. There `dout` must already equal the finished code, on the same edge as the rise of `busy_n`. A restart strobe can also coincide with a running decision sequence. The bench fires one mid-conversion with a different input, and the scoreboard accepts only the second input's quantized value.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
    typedef enum logic [1:0] {
        ST_DONE = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } sar_state_e;
endpackage

// File: rtl/sar_rel_sync.sv
`timescale 1ns/1ps
// Retimes the release of the convert strobe onto rising clock edges.
// The low level of the strobe empties the chain asynchronously.
module sar_rel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_n,
    output logic rel
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n or negedge conv_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (!conv_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= (chain_q << 1) | STAGES'(1);
        end
    end

    assign rel = chain_q[STAGES-1];
endmodule

// File: rtl/sar_core.sv
`timescale 1ns/1ps
// Falling-edge sequencer and approximation register.
module sar_core
    import sar_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_n,
    input  logic         rel,
    input  logic         cmp_hi,
    output logic [W-1:0] trial,
    output logic         busy_n
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;
    localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};
    localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

    sar_state_e     state_q, state_d;
    logic [IW-1:0]  idx_q, idx_d;
    logic [W-1:0]   code_q, code_d;
    logic           decide;

    // State register: reset and strobe clear act at once, decisions on falling edges
    always_ff @(negedge clk or negedge rst_n or negedge conv_n) begin
        if (!rst_n) begin
            state_q <= ST_DONE;
            idx_q   <= '0;
            code_q  <= '0;
        end else if (!conv_n) begin
            state_q <= ST_HOLD;
            idx_q   <= TOP_IDX;
            code_q  <= MSB_ONLY;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            code_q  <= code_d;
        end
    end

    // Transitions and bit decisions
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        code_d  = code_q;
        decide  = 1'b0;
        unique case (state_q)
            ST_DONE: decide = 1'b0;
            ST_HOLD: decide = rel;
            ST_RUN:  decide = 1'b1;
            default: decide = 1'b0;
        endcase
        if (decide) begin
            code_d[idx_q] = ~cmp_hi;
            if (idx_q == '0) begin
                state_d = ST_DONE;
            end else begin
                code_d[idx_q - 1'b1] = 1'b1;
                idx_d   = idx_q - 1'b1;
                state_d = ST_RUN;
            end
        end
    end

    // Outputs
    always_comb begin
        trial  = code_q;
        busy_n = (state_q == ST_DONE);
    end
endmodule

// File: rtl/sar_read_port.sv
`timescale 1ns/1ps
// Bus driver model: enable flag plus gated data.
module sar_read_port #(
    parameter int W = 8
) (
    input  logic         rd_n,
    input  logic [W-1:0] code,
    output logic [W-1:0] dout,
    output logic         dout_oe
);
    always_comb begin
        dout_oe = ~rd_n;
        dout    = rd_n ? '0 : code;
    end
endmodule

// File: rtl/sar_adc_ctrl.sv
`timescale 1ns/1ps
module sar_adc_ctrl #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_n,
    input  logic         cmp_hi,
    input  logic         rd_n,
    output logic [W-1:0] trial,
    output logic         busy_n,
    output logic [W-1:0] dout,
    output logic         dout_oe
);
    logic rel;

    sar_rel_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .conv_n (conv_n),
        .rel    (rel)
    );

    sar_core #(.W(W)) i_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .conv_n (conv_n),
        .rel    (rel),
        .cmp_hi (cmp_hi),
        .trial  (trial),
        .busy_n (busy_n)
    );

    sar_read_port #(.W(W)) i_rd (
        .rd_n    (rd_n),
        .code    (trial),
        .dout    (dout),
        .dout_oe (dout_oe)
    );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
`timescale 1ns/1ps
module sar_adc_ctrl_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         conv_n,
    input logic         rd_n,
    input logic [W-1:0] trial,
    input logic         busy_n,
    input logic [W-1:0] dout,
    input logic         dout_oe
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    // R1
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_n |-> (!busy_n && trial == MID));

    // R4
    active_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |-> (trial != '0));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && $past(busy_n)) |-> $stable(trial));

    // R7
    read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (dout_oe && dout == trial));

    // R7
    bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> (!dout_oe && dout == '0));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.W(W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .conv_n  (conv_n),
    .rd_n    (rd_n),
    .trial   (trial),
    .busy_n  (busy_n),
    .dout    (dout),
    .dout_oe (dout_oe)
);

// File: tb/test_sar_adc_ctrl.sv
`timescale 1ns/1ps
module test_sar_adc_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [9:0] vin4 = '0;   // analog input in quarter-LSB units
    logic       cmp_hi;
    logic [7:0] trial, dout;
    logic       busy_n, dout_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    // Behavioural comparator: DAC level (code * 4) above the input
    assign cmp_hi = ({trial, 2'b00} > vin4);

    sar_adc_ctrl i_sar_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .cmp_hi(cmp_hi), .rd_n(rd_n),
        .trial(trial), .busy_n(busy_n), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Driver: strobe for one clock, queue the ideal quantizer result
    task automatic start_conv(input logic [9:0] v);
        @(posedge clk); #1;
        if (!busy_n && exp_q.size() > 0) void'(exp_q.pop_back());
        vin4   = v;
        conv_n = 1'b0;
        @(posedge clk); #1;
        conv_n = 1'b1;
        exp_q.push_back(v[9:2]);
    endtask

    task automatic convert(input logic [9:0] v);
        start_conv(v);
        @(posedge busy_n); #2;
    endtask

    // Monitor: compare each completed result with the queue head
    initial begin
        wait (rst_n);
        forever begin
            @(posedge busy_n); #1;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected completion", trial, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(trial == e, "R5 quantized code", trial, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R11 reset state
        #1;
        chk(busy_n == 1'b1, "R11 busy_n in reset", busy_n, 1);
        chk(trial == 8'h00, "R11 trial in reset", trial, 0);
        chk(dout_oe == 1'b0, "R11 dout_oe in reset", dout_oe, 0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1 chk(busy_n && trial == 8'h00, "R11 idle after reset", trial, 0);

        // R1 hold while strobe low
        vin4 = 10'd600;
        conv_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk); #1;
            chk(trial == 8'h80 && !busy_n, "R1 held cleared", {busy_n, trial}, 9'h080);
        end
        // R3 MSB timing, R4 decision rule, R6 busy edge
        conv_n = 1'b1;
        exp_q.push_back(8'd150);
        repeat (2) @(posedge clk);
        #1 chk(trial == 8'h80, "R3 no decision before falling edge", trial, 8'h80);
        #2 chk(trial == 8'hC0, "R3 R4 MSB kept, next bit set", trial, 8'hC0);
        repeat (7) @(posedge clk);
        #1 chk(busy_n == 1'b0, "R6 busy low before LSB edge", busy_n, 0);
        #2 chk(busy_n == 1'b1, "R6 busy high after LSB edge", busy_n, 1);
        #2;

        // R4 cleared MSB case
        vin4 = 10'd100;
        conv_n = 1'b0;
        @(posedge clk); #1 conv_n = 1'b1;
        exp_q.push_back(8'd25);
        repeat (2) @(posedge clk);
        #3 chk(trial == 8'h40, "R4 MSB cleared, next bit set", trial, 8'h40);
        @(posedge busy_n); #2;

        // R5 sweep including both ends
        for (int v = 0; v < 1024; v += 11) convert(10'(v));
        convert(10'd1023);
        convert(10'd3);
        convert(10'd4);

        // R9 result held, comparator ignored
        convert(10'd333);
        for (int k = 0; k < 6; k++) begin
            vin4 = 10'(k * 170);
            @(posedge clk); #1;
            chk(trial == 8'd83 && busy_n, "R9 result held", trial, 83);
        end

        // R7 R8 reads
        chk(!dout_oe && dout == 8'h00, "R7 bus off", {dout_oe, dout}, 0);
        for (int k = 0; k < 3; k++) begin
            rd_n = 1'b0; #1;
            chk(dout_oe && dout == 8'd83, "R7 R8 read value", {dout_oe, dout}, 9'h153);
            rd_n = 1'b1; #1;
            chk(trial == 8'd83, "R8 read non-destructive", trial, 83);
        end

        // Read held across the LSB decision (R7 with R6)
        rd_n = 1'b0;
        start_conv(10'd777);
        @(posedge busy_n); #1;
        chk(dout == 8'd194 && dout_oe, "R7 bus at completion", dout, 194);
        rd_n = 1'b1;
        #2;

        // R2 restart mid-conversion
        start_conv(10'd1000);
        repeat (4) @(posedge clk);
        start_conv(10'd40);
        @(posedge busy_n); #2;
        chk(trial == 8'd10, "R2 restart result", trial, 10);

        // R10 short strobe between edges
        @(posedge clk); #1;
        vin4 = 10'd512;
        conv_n = 1'b0;
        #0.5;
        chk(!busy_n && trial == 8'h80, "R10 async clear", {busy_n, trial}, 9'h080);
        conv_n = 1'b1;
        exp_q.push_back(8'd128);
        @(posedge busy_n); #2;
        chk(trial == 8'd128, "R10 full conversion after short pulse", trial, 128);

        repeat (4) @(posedge clk);
        chk(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
        finish_run();
    end
endmodule